// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits at the front of an Ethernet receive path and looks only at the destination-address field of each incoming frame. The six address bytes arrive one per valid strobe. A start-of-frame pulse marks the first byte, and an end-of-frame pulse covers frames that stop early. Once the sixth byte has been taken, the block reports two things: whether the frame should be kept, and whether the address failed to match the configured filter (a "miss").

There are three kinds of address. An all-ones address is a broadcast, and a mode bit can reject it. Group addresses, and every address when the hash-all mode is on, are checked against a 64-bit hash table. The table is indexed by six bits of a CRC-32 over the address. Any other address is a unicast, and it must equal the programmed station address byte for byte. A promiscuous mode keeps frames that missed and still reports the miss, so the receive status can record it.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `decision_valid`, `accept` and `miss` are 0. They become valid in the cycle after the sixth address byte is taken. They hold until the next `sof`, and bytes or `frame_end` pulses arriving in between change nothing.
- R2: A destination of six 0xFF bytes is a broadcast. Its miss equals `mode_bcast_reject`, whatever the hash and station settings are.
- R3: A non-broadcast frame takes the hash path when bit 0 of address byte 0 is 1 or when `mode_hash_all` is 1. Otherwise it takes the unicast path.
- R4: The hash CRC starts at 0xFFFFFFFF and takes the bytes in order, each byte LSB first. For each bit, carry = crc[31] XOR the data bit. The CRC shifts left by one and is XORed with 0x04C11DB7 when carry is 1.
- R5: The hash index is crc[31:26]. Index bit 5 set selects `hash_hi` and clear selects `hash_lo`. Index bits 4:0 pick the bit within that word, and a 0 bit means a miss.
- R6: On the unicast path, byte 0 must equal `stn_hi[15:8]` and byte 1 must equal `stn_hi[7:0]`. Bytes 2 to 5 must equal `stn_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order. A mismatch in any byte is a miss.
- R7: A `frame_end` pulse before the sixth byte ends the frame as a miss, and the outputs become valid in the following cycle.
- R8: `accept` = NOT miss OR `mode_promisc`. `miss` is reported as 1 even when the frame is kept.
- R9: `sof` restarts address collection, even in the middle of an unfinished address. Idle cycles between valid bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Marks the first address byte, or restarts collection |
| byte_valid | input | 1 | `byte_data` carries an address byte |
| byte_data | input | 8 | Address byte, in order from byte 0 |
| frame_end | input | 1 | Frame ended; a miss if fewer than six bytes came |
| mode_bcast_reject | input | 1 | Treat broadcast as a miss |
| mode_hash_all | input | 1 | Send every non-broadcast address through the hash |
| mode_promisc | input | 1 | Keep frames that missed |
| hash_lo | input | 32 | Hash bits for indices 0 to 31 |
| hash_hi | input | 32 | Hash bits for indices 32 to 63 |
| stn_lo | input | 32 | Station address bytes 2 to 5 |
| stn_hi | input | 16 | Station address bytes 0 and 1 |
| decision_valid | output | 1 | Verdict is valid |
| accept | output | 1 | Keep the frame |
| miss | output | 1 | Address did not pass the filter |

## Verification
Broadcast frames are sent with the reject bit set and cleared, with an empty hash table and with hash-all mode on. This shows that broadcast detection comes before both other paths. Group addresses are run against a table holding only the computed hash bit, and then against a table holding every bit except that one. A wrong CRC, a wrong index slice or a swapped hash word therefore turns a hit into a miss. Unicast frames mismatch in the first byte and in the last byte, which checks the byte order across the two station words. Hash-all mode is tried with a matching station address and an empty table. The remaining cases are short frames ended by `frame_end`, idle gaps between bytes, a `sof` restart mid-address and trailing bytes after the verdict, which together check when the verdict is produced and how long it is held.

// File: rtl/rxf_pkg.sv
// Shared constants and types for the receive destination filter.
// Assumes a six-byte destination address delivered one byte per strobe.
package rxf_pkg;
    localparam int unsigned ADDR_BYTES = 6;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam int unsigned CRC_W      = 32;
    localparam int unsigned HIDX_W     = 6;

    typedef struct packed {
        logic bcast_reject;
        logic hash_all;
        logic promisc;
    } rxf_mode_t;
endpackage

// File: rtl/rxf_crc_step.sv
// Advances the address-hash CRC by one byte, least significant bit first.
// Purely combinational; the caller holds the running value.
module rxf_crc_step #(
    parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
    input  logic [31:0] crc_in,
    input  logic [7:0]  data,
    output logic [31:0] crc_out
);
    // Eight serial steps, each shifting left and folding in the polynomial on carry.
    always_comb begin
        logic [31:0] c;
        logic        carry;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            carry = c[31] ^ data[i];
            c     = {c[30:0], 1'b0};
            if (carry) c = c ^ POLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/rxf_addr_cmp.sv
// Compares one incoming address byte with the matching station byte.
// Station bytes 0..1 come from stn_hi (high byte first), 2..5 from stn_lo.
module rxf_addr_cmp
    import rxf_pkg::*;
(
    input  logic [31:0]       stn_lo,
    input  logic [15:0]       stn_hi,
    input  logic [CNT_W-1:0]  idx,
    input  logic [BYTE_W-1:0] data,
    output logic              match
);
    localparam int unsigned ST_W = ADDR_BYTES * BYTE_W;

    logic [ST_W-1:0]   station;
    logic [BYTE_W-1:0] expect_b [ADDR_BYTES];

    assign station = {stn_hi, stn_lo};

    // Byte k of the address sits at the k-th byte counted from the MSB end.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_exp
        assign expect_b[k] = station[(ADDR_BYTES-1-k)*BYTE_W +: BYTE_W];
    end

    // Select the expected byte for the current position and compare.
    always_comb begin
        match = 1'b0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == CNT_W'(k)) match = (data == expect_b[k]);
        end
    end
endmodule

// File: rtl/rxf_verdict.sv
// Turns the collected address facts into a miss flag and a keep decision.
// Broadcast wins over hash, hash wins over unicast.
module rxf_verdict
    import rxf_pkg::*;
(
    input  logic             is_bcast,
    input  logic             hash_path,
    input  logic             uni_ok,
    input  logic [CRC_W-1:0] crc,
    input  logic [31:0]      hash_lo,
    input  logic [31:0]      hash_hi,
    input  rxf_mode_t        mode,
    output logic             miss,
    output logic             accept
);
    logic [HIDX_W-1:0] hidx;
    logic              hash_bit;

    assign hidx = crc[CRC_W-1 -: HIDX_W];

    // Table lookup: top index bit chooses the word, the rest choose the bit.
    always_comb begin
        if (hidx[HIDX_W-1]) hash_bit = hash_hi[hidx[HIDX_W-2:0]];
        else                hash_bit = hash_lo[hidx[HIDX_W-2:0]];
    end

    // Path priority and promiscuous override.
    always_comb begin
        if (is_bcast)       miss = mode.bcast_reject;
        else if (hash_path) miss = ~hash_bit;
        else                miss = ~uni_ok;
        accept = ~miss | mode.promisc;
    end
endmodule

// File: rtl/rx_dest_filter.sv
// Receive destination-address filter. Collects six address bytes after sof,
// then registers a verdict held until the next sof. Assumes sof coincides
// with byte 0 when byte_valid is high; a sof alone only restarts collection.
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7,
    parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        frame_end,
    input  logic        mode_bcast_reject,
    input  logic        mode_hash_all,
    input  logic        mode_promisc,
    input  logic [31:0] hash_lo,
    input  logic [31:0] hash_hi,
    input  logic [31:0] stn_lo,
    input  logic [15:0] stn_hi,
    output logic        decision_valid,
    output logic        accept,
    output logic        miss
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    rxf_mode_t        mode;
    logic [CNT_W-1:0] cnt_q, cnt_e;
    logic             done_q, done_e;
    logic             ones_q, ones_e, ones_n;
    logic             uni_q, uni_e, uni_n;
    logic             grp_q, grp_e, grp_n;
    logic [CRC_W-1:0] crc_q, crc_e, crc_n;
    logic             take, last, short_end;
    logic             byte_match;
    logic             v_miss, v_accept;

    assign mode = '{bcast_reject: mode_bcast_reject,
                    hash_all:     mode_hash_all,
                    promisc:      mode_promisc};

    // Effective state: sof presents a fresh frame to this cycle's byte.
    always_comb begin
        if (sof) begin
            cnt_e  = '0;
            done_e = 1'b0;
            ones_e = 1'b1;
            uni_e  = 1'b1;
            grp_e  = 1'b0;
            crc_e  = CRC_INIT;
        end else begin
            cnt_e  = cnt_q;
            done_e = done_q;
            ones_e = ones_q;
            uni_e  = uni_q;
            grp_e  = grp_q;
            crc_e  = crc_q;
        end
    end

    // Byte acceptance and end-of-address detection.
    always_comb begin
        take      = byte_valid && !done_e && (cnt_e < CNT_W'(ADDR_BYTES));
        last      = take && (cnt_e == LAST_IDX);
        short_end = frame_end && !done_e && !last;
    end

    rxf_crc_step #(.POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_e),
        .data    (byte_data),
        .crc_out (crc_n)
    );

    rxf_addr_cmp u_cmp (
        .stn_lo (stn_lo),
        .stn_hi (stn_hi),
        .idx    (cnt_e),
        .data   (byte_data),
        .match  (byte_match)
    );

    // Address facts including the byte being taken now.
    always_comb begin
        ones_n = ones_e & (byte_data == 8'hFF);
        uni_n  = uni_e & byte_match;
        grp_n  = (cnt_e == '0) ? byte_data[0] : grp_e;
    end

    rxf_verdict u_verdict (
        .is_bcast  (ones_n),
        .hash_path (grp_n | mode.hash_all),
        .uni_ok    (uni_n),
        .crc       (crc_n),
        .hash_lo   (hash_lo),
        .hash_hi   (hash_hi),
        .mode      (mode),
        .miss      (v_miss),
        .accept    (v_accept)
    );

    // Collection state: restart on sof, advance on each taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            ones_q <= 1'b1;
            uni_q  <= 1'b1;
            grp_q  <= 1'b0;
            crc_q  <= CRC_INIT;
        end else begin
            cnt_q  <= take ? cnt_e + CNT_W'(1) : cnt_e;
            done_q <= done_e | last | short_end;
            ones_q <= take ? ones_n : ones_e;
            uni_q  <= take ? uni_n  : uni_e;
            grp_q  <= take ? grp_n  : grp_e;
            crc_q  <= take ? crc_n  : crc_e;
        end
    end

    // Verdict registers: cleared by sof, loaded once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decision_valid <= 1'b0;
            accept         <= 1'b0;
            miss           <= 1'b0;
        end else if (last) begin
            decision_valid <= 1'b1;
            accept         <= v_accept;
            miss           <= v_miss;
        end else if (short_end) begin
            decision_valid <= 1'b1;
            accept         <= mode.promisc;
            miss           <= 1'b1;
        end else if (sof) begin
            decision_valid <= 1'b0;
            accept         <= 1'b0;
            miss           <= 1'b0;
        end
    end
endmodule

// File: rtl/rxf_filter_checks.sv
// Temporal checks on the filter's verdict outputs, bound into the top.
module rxf_filter_checks (
    input logic clk,
    input logic rst_n,
    input logic sof,
    input logic mode_promisc,
    input logic decision_valid,
    input logic accept,
    input logic miss
);
    // R1: a verdict stays valid until the next sof
    a_r1_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && !sof |=> decision_valid);

    // R1: verdict values do not move while held
    a_r1_stable_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && !sof |=> $stable(accept) && $stable(miss));

    // R1: no verdict values outside a valid window
    a_r1_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_valid |-> !accept && !miss);

    // R8: a frame that passed the filter is always kept
    a_r8_pass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && !miss |-> accept);

    // R8: a kept miss needs promiscuous mode when the verdict was formed
    a_r8_kept_miss_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(decision_valid) && accept && miss |-> $past(mode_promisc));

    // R9: sof starts a new frame, so no verdict in the next cycle
    a_r9_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !decision_valid || $past(decision_valid) == 1'b0);
endmodule

bind rx_dest_filter rxf_filter_checks u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .sof            (sof),
    .mode_promisc   (mode_promisc),
    .decision_valid (decision_valid),
    .accept         (accept),
    .miss           (miss)
);

// File: tb/rx_dest_filter_bench.sv
module rx_dest_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, byte_valid = 1'b0, frame_end = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        mode_bcast_reject = 1'b0, mode_hash_all = 1'b0, mode_promisc = 1'b0;
    logic [31:0] hash_lo = '0, hash_hi = '0, stn_lo = '0;
    logic [15:0] stn_hi = '0;
    logic        decision_valid, accept, miss;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
    localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;

    rx_dest_filter u_rx_dest_filter (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
        .byte_data(byte_data), .frame_end(frame_end),
        .mode_bcast_reject(mode_bcast_reject), .mode_hash_all(mode_hash_all),
        .mode_promisc(mode_promisc), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .stn_lo(stn_lo), .stn_hi(stn_hi), .decision_valid(decision_valid),
        .accept(accept), .miss(miss)
    );

    always #10 clk = ~clk;

    // CRC over the address as the requirement defines it; index = crc[31:26].
    function automatic logic [5:0] ref_index(input logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = da[47-8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                logic carry = c[31] ^ b[i];
                c = {c[30:0], 1'b0};
                if (carry) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[31:26];
    endfunction

    // Hash table pair with only one index set, or with all but one set.
    task automatic set_hash(input logic [5:0] idx, input bit only);
        logic [63:0] t = 64'd1 << idx;
        if (!only) t = ~t;
        hash_hi = t[63:32];
        hash_lo = t[31:0];
    endtask

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] got = {decision_valid, accept, miss};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s valid/accept/miss actual=%b expected=%b", req, got, exp);
        end
    endtask

    // Send n address bytes; gap idle cycles between bytes; leave outputs visible.
    task automatic send(input logic [47:0] da, input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sof = (k == 0);
            byte_valid = 1'b1;
            byte_data = da[47-8*k -: 8];
            for (int g = 0; g < gap && k < n - 1; g++) begin
                @(negedge clk);
                sof = 1'b0;
                byte_valid = 1'b0;
            end
        end
        @(negedge clk);
        sof = 1'b0;
        byte_valid = 1'b0;
    endtask

    task automatic end_short();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset", 3'b000);
    endtask

    task automatic t_bcast();
        mode_bcast_reject = 0; send(BCAST, 6, 0); check("R2 bcast pass", 3'b110);
        mode_bcast_reject = 1; send(BCAST, 6, 0); check("R2 bcast reject", 3'b101);
        mode_promisc = 1;      send(BCAST, 6, 0); check("R8 bcast promisc", 3'b111);
        mode_promisc = 0; mode_bcast_reject = 0;
        hash_lo = '0; hash_hi = '0; mode_hash_all = 1;
        send(BCAST, 6, 0); check("R3 bcast before hash", 3'b110);
        mode_hash_all = 0;
    endtask

    task automatic t_unicast();
        send(STATION, 6, 0); check("R6 unicast match", 3'b110);
        send(STATION ^ 48'h00_00_00_00_00_01, 6, 0); check("R6 byte5 mismatch", 3'b101);
        send(STATION ^ 48'h04_00_00_00_00_00, 6, 0); check("R6 byte0 mismatch", 3'b101);
        send(48'h55_44_33_22_11_02 & 48'hFE_FF_FF_FF_FF_FF, 6, 0);
        check("R6 reversed order", 3'b101);
        mode_promisc = 1;
        send(STATION ^ 48'h00_00_10_00_00_00, 6, 0); check("R8 unicast promisc", 3'b111);
        mode_promisc = 0;
    endtask

    task automatic t_hash();
        logic [47:0] mc1 = 48'h01_00_5E_00_00_FB;
        logic [47:0] mc2 = 48'h33_33_00_00_00_01;
        set_hash(ref_index(mc1), 1); send(mc1, 6, 0); check("R4 R5 hash hit a", 3'b110);
        set_hash(ref_index(mc1), 0); send(mc1, 6, 0); check("R5 hash miss a", 3'b101);
        set_hash(ref_index(mc2), 1); send(mc2, 6, 0); check("R4 R5 hash hit b", 3'b110);
        set_hash(ref_index(mc2), 0); send(mc2, 6, 0); check("R5 hash miss b", 3'b101);
        // Hash-all: station-matching address uses the table (R3).
        mode_hash_all = 1;
        hash_lo = '0; hash_hi = '0;
        send(STATION, 6, 0); check("R3 hash_all empty table", 3'b101);
        set_hash(ref_index(48'h02_99_88_77_66_55), 1);
        send(48'h02_99_88_77_66_55, 6, 0); check("R3 hash_all hit", 3'b110);
        mode_hash_all = 0;
        // Group bit set but station-equal bytes otherwise: still hash path (R3).
        hash_lo = '0; hash_hi = '0;
        send(STATION | 48'h01_00_00_00_00_00, 6, 0); check("R3 group bit", 3'b101);
    endtask

    task automatic t_short();
        send(STATION, 4, 0); check("R1 no verdict mid frame", 3'b000);
        end_short(); check("R7 short frame", 3'b101);
        mode_promisc = 1;
        send(BCAST, 5, 0); end_short(); check("R7 short promisc", 3'b111);
        mode_promisc = 0;
    endtask

    task automatic t_hold_restart();
        send(STATION, 6, 0); check("R1 verdict", 3'b110);
        @(negedge clk); byte_valid = 1; byte_data = 8'h77;
        @(negedge clk); byte_valid = 0; frame_end = 1;
        @(negedge clk); frame_end = 0;
        check("R1 hold after trailing", 3'b110);
        send(STATION, 6, 3); check("R9 gaps", 3'b110);
        send(48'hAA_BB_CC_00_00_00, 3, 0);
        send(STATION, 6, 1); check("R9 sof restart", 3'b110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        stn_hi = STATION[47:32];
        stn_lo = STATION[31:0];
        @(negedge clk);
        t_reset();
        t_bcast();
        t_unicast();
        t_hash();
        t_short();
        t_hold_restart();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule